// File: doc/BRIEF.md
# TileLink Request Legality Monitor

A passive checker that sits beside the request (A) channel of a TileLink link and never drives it. On every accepted beat, meaning `a_valid_i` and `a_ready_i` are both high, it decodes the 3-bit opcode. It then checks that the 3-bit param field holds a value that the opcode permits. It also checks that a data-carrying beat has at least one byte lane enabled. A configuration input states whether the link carries the cache-coherence channels. When that input is low, the two acquire opcodes are not allowed.

Data-carrying requests wider than one data word span several beats. The monitor captures the header of the first beat: opcode, param, size, source and address. It compares each later beat of the same message against that captured header. Each violation sets a bit in a sticky error vector, which only reset clears. A single-cycle pulse marks every accepted beat that carried at least one violation. Both outputs are registered and change on the clock edge that samples the offending beat.

Top module: `tl_req_monitor`

## Requirements
- R1: While reset is held, and directly after it, `err_sticky_o` is all zero and `err_pulse_o` is low.
- R2: Arithmetic requests (opcode 2) accept param 0..4 and Logical requests (opcode 3) accept param 0..3. Any other param sets error bit 0.
- R3: Hint requests (opcode 5) accept param 0 or 1. AcquireBlock (opcode 6) and AcquirePerm (opcode 7) accept param 0..2. Any other param sets error bit 0.
- R4: PutFull (opcode 0), PutPartial (opcode 1) and Get (opcode 4) require param 0. Any nonzero param sets error bit 0.
- R5: When `coh_en_i` is low, an accepted beat with opcode 6 or 7 sets error bit 1. When `coh_en_i` is high, these opcodes are legal.
- R6: An accepted beat whose opcode has bit 2 clear (opcodes 0..3, which carry data) and whose mask is zero sets error bit 2. A zero mask on opcodes 4..7 is not an error.
- R7: Sticky error bits never clear except by reset. Clean traffic after an error leaves them unchanged.
- R8: Only a beat with both valid and ready high is checked. The pulse rises in the cycle after such a beat's edge, lasts one cycle, and accompanies that beat's new sticky bits.
- R9: A message with opcode 0..3 and 2^size bytes larger than the data word lasts 2^size / (DATA_W/8) beats. Any other message lasts one beat. After the last beat, the next beat starts a new message with a fresh header.
- R10: On any beat after the first of a message, a difference in opcode, param, size, source or address from the first beat sets error bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coh_en_i | input | 1 | High when the link carries the coherence channels |
| a_valid_i | input | 1 | Request channel valid |
| a_ready_i | input | 1 | Request channel ready |
| a_opcode_i | input | 3 | Request opcode |
| a_param_i | input | 3 | Request param |
| a_size_i | input | SIZE_W | log2 of the message byte count |
| a_source_i | input | SRC_W | Requester identifier |
| a_address_i | input | ADDR_W | Request address |
| a_mask_i | input | DATA_W/8 | Byte-lane enables |
| err_pulse_o | output | 1 | One-cycle flag: the last accepted beat had a violation |
| err_sticky_o | output | 4 | Sticky errors: bit0 param, bit1 opcode, bit2 mask, bit3 header |

## Verification
The header comparison and the param decode both run on every later beat of a burst. A single beat can therefore break both rules at once. The bench provokes this by sending the second beat of a four-beat PutFull with param changed to 1. That one change both alters the header and breaks the zero-param rule. The bench expects one pulse with bits 0 and 3 set together. A second coincidence uses an acquire with coherence disabled and an out-of-range grow code, and it must raise bits 0 and 1 in the same cycle.

// File: rtl/tl_mon_pkg.sv
package tl_mon_pkg;
  typedef enum logic [2:0] {
    OP_PUT_FULL = 3'd0,
    OP_PUT_PART = 3'd1,
    OP_ARITH    = 3'd2,
    OP_LOGIC    = 3'd3,
    OP_GET      = 3'd4,
    OP_HINT     = 3'd5,
    OP_ACQ_BLK  = 3'd6,
    OP_ACQ_PERM = 3'd7
  } a_op_e;

  localparam int unsigned ERR_W     = 4;
  localparam int unsigned ERR_PARAM = 0;
  localparam int unsigned ERR_OPC   = 1;
  localparam int unsigned ERR_MASK  = 2;
  localparam int unsigned ERR_HDR   = 3;

  // opcodes 0..3 carry data on the request channel
  function automatic logic op_has_data(logic [2:0] op);
    return ~op[2];
  endfunction
endpackage

// File: rtl/tl_param_check.sv
module tl_param_check
  import tl_mon_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic [2:0] param_i,
  input  logic       coh_en_i,
  output logic       param_bad_o,
  output logic       opc_bad_o
);
  always_comb begin
    param_bad_o = 1'b0;
    opc_bad_o   = 1'b0;
    unique case (a_op_e'(op_i))
      OP_PUT_FULL, OP_PUT_PART, OP_GET: param_bad_o = (param_i != 3'd0);
      OP_ARITH:                         param_bad_o = (param_i > 3'd4);
      OP_LOGIC:                         param_bad_o = (param_i > 3'd3);
      OP_HINT:                          param_bad_o = (param_i > 3'd1);
      OP_ACQ_BLK, OP_ACQ_PERM: begin
        param_bad_o = (param_i > 3'd2);
        opc_bad_o   = ~coh_en_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tl_burst_track.sv
module tl_burst_track
  import tl_mon_pkg::*;
#(
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned SRC_W    = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BYTE_OFF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [2:0]        op_i,
  input  logic [2:0]        param_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hdr_bad_o
);
  localparam int unsigned SPAN_W = 1 << SIZE_W;
  localparam int unsigned HDR_W  = 6 + SIZE_W + SRC_W + ADDR_W;

  logic [SPAN_W-1:0] span_m1, beats_m1, left_q;
  logic [HDR_W-1:0]  hdr_cur, hdr_q;
  logic              mid_q;

  assign hdr_cur  = {op_i, param_i, size_i, src_i, addr_i};
  assign span_m1  = (SPAN_W'(1) << size_i) - SPAN_W'(1);
  assign beats_m1 = op_has_data(op_i) ? (span_m1 >> BYTE_OFF) : '0;

  assign hdr_bad_o = fire_i && mid_q && (hdr_cur != hdr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q  <= 1'b0;
      left_q <= '0;
      hdr_q  <= '0;
    end else if (fire_i) begin
      if (!mid_q) begin
        if (beats_m1 != '0) begin
          mid_q  <= 1'b1;
          left_q <= beats_m1;
          hdr_q  <= hdr_cur;
        end
      end else begin
        left_q <= left_q - SPAN_W'(1);
        if (left_q == SPAN_W'(1)) mid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tl_err_collect.sv
module tl_err_collect #(
  parameter int unsigned ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] err_now_i,
  output logic [ERR_W-1:0] sticky_o,
  output logic             pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_o <= '0;
      pulse_o  <= 1'b0;
    end else begin
      sticky_o <= sticky_o | err_now_i;
      pulse_o  <= |err_now_i;
    end
  end
endmodule

// File: rtl/tl_req_monitor.sv
module tl_req_monitor
  import tl_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                coh_en_i,
  input  logic                a_valid_i,
  input  logic                a_ready_i,
  input  logic [2:0]          a_opcode_i,
  input  logic [2:0]          a_param_i,
  input  logic [SIZE_W-1:0]   a_size_i,
  input  logic [SRC_W-1:0]    a_source_i,
  input  logic [ADDR_W-1:0]   a_address_i,
  input  logic [DATA_W/8-1:0] a_mask_i,
  output logic                err_pulse_o,
  output logic [ERR_W-1:0]    err_sticky_o
);
  localparam int unsigned BYTES    = DATA_W / 8;
  localparam int unsigned BYTE_OFF = $clog2(BYTES);

  logic fire, param_bad, opc_bad, hdr_bad, mask_bad;
  logic [ERR_W-1:0] err_now;

  assign fire     = a_valid_i & a_ready_i;
  assign mask_bad = op_has_data(a_opcode_i) && (a_mask_i == '0);

  tl_param_check u_param (
    .op_i        (a_opcode_i),
    .param_i     (a_param_i),
    .coh_en_i    (coh_en_i),
    .param_bad_o (param_bad),
    .opc_bad_o   (opc_bad)
  );

  tl_burst_track #(
    .SIZE_W   (SIZE_W),
    .SRC_W    (SRC_W),
    .ADDR_W   (ADDR_W),
    .BYTE_OFF (BYTE_OFF)
  ) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .op_i      (a_opcode_i),
    .param_i   (a_param_i),
    .size_i    (a_size_i),
    .src_i     (a_source_i),
    .addr_i    (a_address_i),
    .hdr_bad_o (hdr_bad)
  );

  always_comb begin
    err_now            = '0;
    err_now[ERR_PARAM] = fire & param_bad;
    err_now[ERR_OPC]   = fire & opc_bad;
    err_now[ERR_MASK]  = fire & mask_bad;
    err_now[ERR_HDR]   = hdr_bad;
  end

  tl_err_collect #(.ERR_W(ERR_W)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_now_i (err_now),
    .sticky_o  (err_sticky_o),
    .pulse_o   (err_pulse_o)
  );
endmodule

// File: rtl/tl_req_monitor_chk.sv
module tl_req_monitor_chk
  import tl_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                coh_en_i,
  input logic                a_valid_i,
  input logic                a_ready_i,
  input logic [2:0]          a_opcode_i,
  input logic [DATA_W/8-1:0] a_mask_i,
  input logic                err_pulse_o,
  input logic [ERR_W-1:0]    err_sticky_o
);
  AST_STICKY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sticky_o & $past(err_sticky_o)) == $past(err_sticky_o)); // R7

  AST_PULSE_NEEDS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> $past(a_valid_i && a_ready_i)); // R8

  AST_PULSE_HAS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> (err_sticky_o != '0)); // R8

  AST_ACQ_NO_COH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_i && !coh_en_i && a_opcode_i[2:1] == 2'b11)
      |=> err_sticky_o[ERR_OPC]); // R5

  AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_i && !a_opcode_i[2] && a_mask_i == '0)
      |=> err_sticky_o[ERR_MASK]); // R6
endmodule

bind tl_req_monitor tl_req_monitor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .coh_en_i     (coh_en_i),
  .a_valid_i    (a_valid_i),
  .a_ready_i    (a_ready_i),
  .a_opcode_i   (a_opcode_i),
  .a_mask_i     (a_mask_i),
  .err_pulse_o  (err_pulse_o),
  .err_sticky_o (err_sticky_o)
);

// File: tb/tb_tl_req_monitor.sv
module tb_tl_req_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coh_en = 1'b0;
  logic        a_valid = 1'b0, a_ready = 1'b0;
  logic [2:0]  a_op = '0, a_param = '0;
  logic [2:0]  a_size = '0;
  logic [3:0]  a_src = '0;
  logic [15:0] a_addr = '0;
  logic [3:0]  a_mask = '0;
  logic        err_pulse;
  logic [3:0]  err_sticky;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tl_req_monitor dut (
    .clk_i (clk), .rst_ni (rst_n), .coh_en_i (coh_en),
    .a_valid_i (a_valid), .a_ready_i (a_ready),
    .a_opcode_i (a_op), .a_param_i (a_param), .a_size_i (a_size),
    .a_source_i (a_src), .a_address_i (a_addr), .a_mask_i (a_mask),
    .err_pulse_o (err_pulse), .err_sticky_o (err_sticky)
  );

  // {opcode, param, coh_en, mask, expected error bits}; size 2 = one beat
  localparam logic [14:0] VEC [16] = '{
    {3'd0, 3'd0, 1'b0, 4'hF, 4'b0000},
    {3'd0, 3'd1, 1'b0, 4'hF, 4'b0001},
    {3'd1, 3'd0, 1'b0, 4'h0, 4'b0100},
    {3'd2, 3'd4, 1'b0, 4'h1, 4'b0000},
    {3'd2, 3'd5, 1'b0, 4'h1, 4'b0001},
    {3'd3, 3'd3, 1'b0, 4'h8, 4'b0000},
    {3'd3, 3'd4, 1'b0, 4'h8, 4'b0001},
    {3'd4, 3'd0, 1'b0, 4'h0, 4'b0000},
    {3'd4, 3'd2, 1'b0, 4'hF, 4'b0001},
    {3'd5, 3'd1, 1'b0, 4'h0, 4'b0000},
    {3'd5, 3'd2, 1'b0, 4'h0, 4'b0001},
    {3'd6, 3'd2, 1'b1, 4'h0, 4'b0000},
    {3'd7, 3'd3, 1'b1, 4'h0, 4'b0001},
    {3'd6, 3'd0, 1'b0, 4'h0, 4'b0010},
    {3'd7, 3'd3, 1'b0, 4'h0, 4'b0011},
    {3'd2, 3'd7, 1'b0, 4'h0, 4'b0101}
  };

  task automatic check(input string req, input logic [4:0] exp);
    n_chk++;
    if ({err_pulse, err_sticky} !== exp) begin
      n_err++;
      $display("FAIL %s: {pulse,sticky} actual=%b expected=%b", req, {err_pulse, err_sticky}, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; a_valid = 1'b0; a_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one cycle at the negedge; sample just after the next posedge
  task automatic beat(input logic v, input logic r, input logic [2:0] op, input logic [2:0] pa,
                      input logic [2:0] sz, input logic [3:0] src, input logic [15:0] ad,
                      input logic [3:0] mk);
    @(negedge clk);
    a_valid = v; a_ready = r; a_op = op; a_param = pa;
    a_size = sz; a_src = src; a_addr = ad; a_mask = mk;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    beat(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 4'd0, 16'd0, 4'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state, checked while reset is held and then after it
    #3; check("R1", 5'b0);
    do_reset();
    #1; check("R1", 5'b0);

    for (int i = 0; i < 16; i++) begin
      logic [2:0] op, pa; logic ce; logic [3:0] mk, ex; string tag;
      {op, pa, ce, mk, ex} = VEC[i];
      if (ex[1])              tag = "R5";
      else if (ex[2])         tag = "R6";
      else if (op inside {3'd2, 3'd3}) tag = "R2";
      else if (op >= 3'd5)    tag = "R3";
      else                    tag = "R4";
      do_reset();
      coh_en = ce;
      beat(1'b1, 1'b1, op, pa, 3'd2, 4'd1, 16'h0010, mk);
      check(tag, {ex != 4'b0, ex});
      idle();
      check("R8", {1'b0, ex});
    end

    // R8: no handshake, no check
    do_reset(); coh_en = 1'b0;
    beat(1'b1, 1'b0, 3'd7, 3'd7, 3'd2, 4'd0, 16'd0, 4'h0);
    check("R8", 5'b0);
    beat(1'b0, 1'b1, 3'd0, 3'd5, 3'd2, 4'd0, 16'd0, 4'h0);
    check("R8", 5'b0);

    // R9: clean 4-beat burst, then a differing single-beat message
    do_reset();
    for (int b = 0; b < 4; b++) begin
      beat(1'b1, 1'b1, 3'd0, 3'd0, 3'd4, 4'd3, 16'h0100, 4'hF);
      check("R9", 5'b0);
    end
    beat(1'b1, 1'b1, 3'd4, 3'd0, 3'd2, 4'd9, 16'h0200, 4'h0);
    check("R9", 5'b0);
    // 2-beat burst (size 3) followed by a fresh header
    beat(1'b1, 1'b1, 3'd2, 3'd4, 3'd3, 4'd5, 16'h0300, 4'h3);
    beat(1'b1, 1'b1, 3'd2, 3'd4, 3'd3, 4'd5, 16'h0300, 4'hC);
    beat(1'b1, 1'b1, 3'd3, 3'd1, 3'd2, 4'd6, 16'h0400, 4'h1);
    check("R9", 5'b0);

    // R10: source changes on beat 3; beat 4 matches again
    do_reset();
    beat(1'b1, 1'b1, 3'd1, 3'd0, 3'd4, 4'd1, 16'h0040, 4'hF);
    beat(1'b1, 1'b1, 3'd1, 3'd0, 3'd4, 4'd1, 16'h0040, 4'hF);
    check("R10", 5'b0);
    beat(1'b1, 1'b1, 3'd1, 3'd0, 3'd4, 4'd2, 16'h0040, 4'hF);
    check("R10", 5'b11000);
    beat(1'b1, 1'b1, 3'd1, 3'd0, 3'd4, 4'd1, 16'h0040, 4'hF);
    check("R10", 5'b01000);
    // R7: clean traffic keeps sticky bits
    beat(1'b1, 1'b1, 3'd4, 3'd0, 3'd2, 4'd1, 16'h0040, 4'h0);
    check("R7", 5'b01000);

    // address change on beat 2 of a 2-beat message
    do_reset();
    beat(1'b1, 1'b1, 3'd3, 3'd2, 3'd3, 4'd4, 16'h0080, 4'hF);
    beat(1'b1, 1'b1, 3'd3, 3'd2, 3'd3, 4'd4, 16'h0084, 4'hF);
    check("R10", 5'b11000);

    // same cycle: header change that is also an illegal param (R4 + R10)
    do_reset();
    beat(1'b1, 1'b1, 3'd0, 3'd0, 3'd4, 4'd7, 16'h0500, 4'hF);
    beat(1'b1, 1'b1, 3'd0, 3'd1, 3'd4, 4'd7, 16'h0500, 4'hF);
    check("R4", 5'b11001);
    idle();
    check("R7", 5'b01001);

    // reset clears sticky bits
    do_reset();
    #1; check("R1", 5'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule